// File: doc/BRIEF.md
# Time-Slotted Source-Routed Network Router

This block is the switching element of an on-chip network that carries only guaranteed-service traffic. Traffic moves in fixed flits of three words. An offline slot schedule makes sure that no two flits ever want the same output link in the same cycle. Because of that schedule, the router needs no arbiter, no routing table, no virtual channels and no link-level flow control.

Each input port has a single one-word register. Each input also has a header parser. The parser takes the destination output from the path field of a source-routed packet header and keeps that choice until the end-of-packet word has gone through. The chosen port is turned into a one-hot select that drives a registered crossbar. Every word therefore takes exactly three clock edges from an input pin to an output pin, and consecutive words stay in consecutive cycles.

The header word is forwarded with its consumed routing bits shifted out, so the next hop finds its own selection in the low bits. If the schedule is ever broken and two inputs aim at one output, an assertion reports it. In that case the lower-numbered input still drives the output.

Top module: `tdm_router`

## Requirements
- R1: A synchronous active-low reset clears every output to valid 0, end-of-packet 0 and data 0. After reset, the next valid word on each input is taken as a header, even if a packet was left unfinished before the reset.
- R2: A word driven on an input before clock edge k appears on its output right after edge k+2, which is the third edge. Before that edge the word is not visible on the output.
- R3: The header is the first valid word on an input after reset, or the first valid word after a word with end-of-packet set. The low SEL_W = clog2(NUM_OUT) bits of the header select the output index. The header is forwarded logically shifted right by SEL_W bits, with zeros filling the top bits.
- R4: Non-header words of a packet go to the same output as their header. Their data is not changed. This holds up to and including the word that carries end-of-packet.
- R5: The end-of-packet flag travels with its word and appears on out_eop of the selected output in the same cycle as that word.
- R6: Cycles where an input is not valid change neither that input's held output selection nor its header/body state. The low bits of body words never re-route them.
- R7: An output that no input selects in a cycle drives valid 0, end-of-packet 0 and data 0.
- R8: Inputs that target distinct outputs in the same cycle all pass through at the same time, with no interference between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | NUM_IN | Per-input word valid |
| in_eop | input | NUM_IN | Per-input end-of-packet flag |
| in_data | input | NUM_IN*DATA_W | Input words, input i at bits [i*DATA_W +: DATA_W] |
| out_valid | output | NUM_OUT | Per-output word valid |
| out_eop | output | NUM_OUT | Per-output end-of-packet flag |
| out_data | output | NUM_OUT*DATA_W | Output words, output o at bits [o*DATA_W +: DATA_W] |

## Verification
On every cycle, the assertions check the following:
- the number of valid words leaving the router equals the number that entered three edges earlier;
- body words of a packet keep the selection of their header;
- a forwarded header has its top SEL_W bits cleared;
- idle outputs stay quiet;
- no two inputs ever request the same output.

Only the bench scenarios can show that each word reaches the correct output with the correct value. They cover every input-to-output pairing, packet lengths of one to three flits, gaps inside a packet, and a reset in the middle of a packet. The bench also shows the exact edge on which a word becomes visible.

// File: rtl/tdm_router_pkg.sv
// Package: shared helpers for the time-slotted router.
// Assumes: output counts of at least one; a single output still gets a 1-bit select.
package tdm_router_pkg;

    // Width of the output-select field consumed from a header.
    function automatic int port_sel_bits(input int num_out);
        return (num_out > 1) ? $clog2(num_out) : 1;
    endfunction

endpackage

// File: rtl/tdm_in_stage.sv
// Module: tdm_in_stage
// Purpose: one router input. It registers the incoming word (stage 1). It parses
// the source-routed header, holds the selection until end-of-packet and registers
// the word together with a one-hot output select (stage 2).
// Assumes: DATA_W > SEL_W; the header selection sits in the low SEL_W bits.
module tdm_in_stage #(
    parameter int NUM_OUT = 4,
    parameter int DATA_W  = 16,
    parameter int SEL_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_eop,
    input  logic [DATA_W-1:0] in_data,
    output logic              fwd_valid,
    output logic              fwd_eop,
    output logic [DATA_W-1:0] fwd_data,
    output logic [NUM_OUT-1:0] fwd_sel
);

    logic              s1_valid;
    logic              s1_eop;
    logic [DATA_W-1:0] s1_data;
    logic              in_pkt;
    logic [SEL_W-1:0]  held_port;
    logic              is_hdr;
    logic [SEL_W-1:0]  cur_port;
    logic [DATA_W-1:0] cur_data;
    logic [NUM_OUT-1:0] cur_onehot;

    // Stage 1: one-word input register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_eop   <= 1'b0;
            s1_data  <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_eop   <= in_eop;
            s1_data  <= in_data;
        end
    end

    // Header parse: pick the port from a header, or reuse the held one.
    always_comb begin
        is_hdr   = s1_valid && !in_pkt;
        cur_port = is_hdr ? s1_data[SEL_W-1:0] : held_port;
        cur_data = is_hdr ? (s1_data >> SEL_W) : s1_data;
    end

    // Convert the selected port number into a one-hot crossbar select.
    always_comb begin
        for (int o = 0; o < NUM_OUT; o++) begin
            cur_onehot[o] = (32'(cur_port) == o);
        end
    end

    // Packet tracking: a valid word sets or clears in_pkt; idle cycles hold it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_pkt    <= 1'b0;
            held_port <= '0;
        end else if (s1_valid) begin
            in_pkt    <= !s1_eop;
            held_port <= cur_port;
        end
    end

    // Stage 2: register the parsed word and its one-hot select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_valid <= 1'b0;
            fwd_eop   <= 1'b0;
            fwd_data  <= '0;
            fwd_sel   <= '0;
        end else begin
            fwd_valid <= s1_valid;
            fwd_eop   <= s1_eop;
            fwd_data  <= cur_data;
            fwd_sel   <= s1_valid ? cur_onehot : '0;
        end
    end

    // R3: a forwarded header has its consumed routing bits cleared at the top.
    assert_hdr_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && !in_pkt) |=> (fwd_valid && fwd_data[DATA_W-1 -: SEL_W] == '0));

    // R4: a body word leaves with the selection held from its header.
    assert_port_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && in_pkt) |=> (fwd_sel == (NUM_OUT'(1) << $past(held_port))));

    // R6: an idle cycle leaves the held selection and packet state untouched.
    assert_idle_keeps_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_valid |=> ($stable(held_port) && $stable(in_pkt)));

endmodule

// File: rtl/tdm_xbar_out.sv
// Module: tdm_xbar_out
// Purpose: one crossbar output column with its output register (stage 3).
// Assumes: the schedule gives at most one requester per cycle. If it does not,
// the lowest-numbered requester is taken.
module tdm_xbar_out #(
    parameter int NUM_IN = 4,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_IN-1:0]        req,
    input  logic [NUM_IN-1:0]        req_eop,
    input  logic [NUM_IN*DATA_W-1:0] req_data,
    output logic                     out_valid,
    output logic                     out_eop,
    output logic [DATA_W-1:0]        out_data
);

    logic              win_v;
    logic              win_e;
    logic [DATA_W-1:0] win_d;

    // Column mux: scan from high to low so that the lowest requester wins.
    always_comb begin
        win_v = 1'b0;
        win_e = 1'b0;
        win_d = '0;
        for (int i = NUM_IN - 1; i >= 0; i--) begin
            if (req[i]) begin
                win_v = 1'b1;
                win_e = req_eop[i];
                win_d = req_data[i*DATA_W +: DATA_W];
            end
        end
    end

    // Stage 3: output register; an unselected output is all zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_eop   <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= win_v;
            out_eop   <= win_e;
            out_data  <= win_d;
        end
    end

    // R8: the schedule must never send two inputs to one output in one cycle.
    assert_no_conflict_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req));

    // R7: an output with no requester in a cycle is quiet on the next cycle.
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |=> (!out_valid && !out_eop && out_data == '0));

endmodule

// File: rtl/tdm_router.sv
// Module: tdm_router
// Purpose: top of the time-slotted, source-routed router. It has NUM_IN input
// stages and NUM_OUT crossbar columns, with a fixed latency of three edges from
// input to output.
// Assumes: offline scheduling prevents output collisions; no flow control exists.
module tdm_router #(
    parameter int NUM_IN  = 4,
    parameter int NUM_OUT = 4,
    parameter int DATA_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_IN-1:0]         in_valid,
    input  logic [NUM_IN-1:0]         in_eop,
    input  logic [NUM_IN*DATA_W-1:0]  in_data,
    output logic [NUM_OUT-1:0]        out_valid,
    output logic [NUM_OUT-1:0]        out_eop,
    output logic [NUM_OUT*DATA_W-1:0] out_data
);

    localparam int SEL_W = tdm_router_pkg::port_sel_bits(NUM_OUT);

    logic [NUM_IN-1:0]        s2_valid;
    logic [NUM_IN-1:0]        s2_eop;
    logic [NUM_IN*DATA_W-1:0] s2_data;
    logic [NUM_OUT-1:0]       s2_sel [NUM_IN];
    logic [NUM_IN-1:0]        col_req [NUM_OUT];
    logic [1:0]               since_rst;

    // One parsing input stage per input port.
    for (genvar i = 0; i < NUM_IN; i++) begin : g_in
        tdm_in_stage #(
            .NUM_OUT (NUM_OUT),
            .DATA_W  (DATA_W),
            .SEL_W   (SEL_W)
        ) u_in (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (in_valid[i]),
            .in_eop    (in_eop[i]),
            .in_data   (in_data[i*DATA_W +: DATA_W]),
            .fwd_valid (s2_valid[i]),
            .fwd_eop   (s2_eop[i]),
            .fwd_data  (s2_data[i*DATA_W +: DATA_W]),
            .fwd_sel   (s2_sel[i])
        );
    end

    // Transpose the per-input one-hot selects into per-output request vectors.
    always_comb begin
        for (int o = 0; o < NUM_OUT; o++) begin
            for (int i = 0; i < NUM_IN; i++) begin
                col_req[o][i] = s2_valid[i] && s2_sel[i][o];
            end
        end
    end

    // One crossbar column per output port.
    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
        tdm_xbar_out #(
            .NUM_IN (NUM_IN),
            .DATA_W (DATA_W)
        ) u_col (
            .clk       (clk),
            .rst_n     (rst_n),
            .req       (col_req[o]),
            .req_eop   (s2_eop),
            .req_data  (s2_data),
            .out_valid (out_valid[o]),
            .out_eop   (out_eop[o]),
            .out_data  (out_data[o*DATA_W +: DATA_W])
        );
    end

    // Saturating count of edges since reset, so the latency check never looks before reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    // R2: words leaving now equal the words that entered three edges earlier.
    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> ($countones(out_valid) == $past($countones(in_valid), 3)));

    // R1: the cycle after reset, every output is quiet.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (out_valid == '0 && out_eop == '0 && out_data == '0));

endmodule

// File: tb/sim_tdm_router.sv
// Bench: it sweeps every input/output pairing and several packet lengths, gaps
// and a mid-packet reset. It predicts each output from the requirements,
// three edges after the word was driven.
module sim_tdm_router;

    localparam int N  = 4;
    localparam int M  = 4;
    localparam int DW = 16;
    localparam int SW = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    in_valid = '0;
    logic [N-1:0]    in_eop = '0;
    logic [N*DW-1:0] in_data = '0;
    logic [M-1:0]    out_valid;
    logic [M-1:0]    out_eop;
    logic [M*DW-1:0] out_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int concurrent = 0;
    bit gap_mode = 1'b0;

    // Stimulus for the next step.
    logic [N-1:0]  dv;
    logic [N-1:0]  de;
    logic [DW-1:0] dd [N];

    // Model state and the expectation ring (4 slots, 3-edge latency).
    bit            hdr_pend [N];
    int            port_m [N];
    logic          xv [4][M];
    logic          xe [4][M];
    logic [DW-1:0] xd [4][M];
    int            xtag [4][M];

    always #2 clk = ~clk;

    tdm_router #(.NUM_IN(N), .NUM_OUT(M), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_eop(in_eop),
        .in_data(in_data), .out_valid(out_valid), .out_eop(out_eop), .out_data(out_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            hdr_pend[i] = 1'b1;
            port_m[i] = 0;
        end
        for (int s = 0; s < 4; s++) begin
            for (int o = 0; o < M; o++) begin
                xv[s][o] = 1'b0; xe[s][o] = 1'b0; xd[s][o] = '0; xtag[s][o] = 7;
            end
        end
    endtask

    task automatic clear_stim();
        dv = '0;
        de = '0;
        for (int i = 0; i < N; i++) dd[i] = '0;
    endtask

    // One cycle: check the outputs due now, drive the stimulus, predict its outputs.
    task automatic step();
        int sc;
        int sw;
        int nvalid;
        @(negedge clk);
        sc = (cyc + 1) % 4;
        nvalid = 0;
        for (int o = 0; o < M; o++) begin
            // Tag: 3 header (R3), 4 body (R4), 5 end-of-packet (R5), 6 gap run (R6), 7 idle (R7).
            chk({out_valid[o], out_eop[o], out_data[o*DW +: DW]} == {xv[sc][o], xe[sc][o], xd[sc][o]},
                $sformatf("R%0d out%0d", xtag[sc][o], o),
                32'({out_valid[o], out_eop[o], out_data[o*DW +: DW]}),
                32'({xv[sc][o], xe[sc][o], xd[sc][o]}));
            if (xv[sc][o]) nvalid++;
        end
        if (nvalid == M) concurrent++;
        in_valid = dv;
        in_eop = de;
        for (int i = 0; i < N; i++) in_data[i*DW +: DW] = dd[i];
        sw = cyc % 4;
        for (int o = 0; o < M; o++) begin
            xv[sw][o] = 1'b0; xe[sw][o] = 1'b0; xd[sw][o] = '0; xtag[sw][o] = 7;
        end
        for (int i = 0; i < N; i++) begin
            if (dv[i]) begin
                int p;
                logic [DW-1:0] f;
                int tg;
                if (hdr_pend[i]) begin
                    p = int'(dd[i][SW-1:0]);
                    f = dd[i] >> SW;
                    tg = 3;
                end else begin
                    p = port_m[i];
                    f = dd[i];
                    tg = gap_mode ? 6 : 4;
                end
                if (de[i]) tg = 5;
                port_m[i] = p;
                hdr_pend[i] = de[i];
                xv[sw][p] = 1'b1; xe[sw][p] = de[i]; xd[sw][p] = f; xtag[sw][p] = tg;
            end
        end
        cyc++;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = '0; in_eop = '0; in_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        clear_stim();
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        clear_stim();
        do_reset();

        // R1: all outputs are quiet after reset.
        @(negedge clk);
        chk(out_valid == '0 && out_eop == '0 && out_data == '0, "R1 reset outputs",
            32'(out_valid), 32'h0);

        // R2: a single-word packet from input 0 to output 2 is visible on the third edge, not before.
        clear_stim();
        dv[0] = 1'b1; de[0] = 1'b1; dd[0] = 16'hABC2;
        step();
        clear_stim();
        step();
        step();
        chk(out_valid[2] == 1'b0, "R2 not visible after two edges", 32'(out_valid), 32'h0);
        step();
        chk(out_valid[2] == 1'b1 && out_data[2*DW +: DW] == 16'h2AF0, "R2 visible after third edge",
            32'(out_data[2*DW +: DW]), 32'h2AF0);
        repeat (3) step();

        // R3 R4 R5 R8: all inputs send at once, over two permutations, four shifts and lengths of 1 to 3 flits.
        for (int mul = 1; mul <= 3; mul += 2) begin
            for (int k = 0; k < 4; k++) begin
                for (int len = 1; len <= 3; len++) begin
                    for (int w = 0; w < 3 * len; w++) begin
                        clear_stim();
                        for (int i = 0; i < N; i++) begin
                            int dst;
                            dst = (mul * i + k) % M;
                            dv[i] = 1'b1;
                            de[i] = (w == 3 * len - 1);
                            dd[i] = {4'(k), 2'(len), 2'(i), 6'(w), (w == 0) ? 2'(dst) : 2'(w + i)};
                        end
                        step();
                    end
                end
            end
        end
        clear_stim();
        repeat (4) step();
        chk(concurrent > 0, "R8 all outputs carried words in one cycle", 32'(concurrent), 32'h1);

        // R6: input 1 sends a packet to output 3 with idle gaps; body low bits would point elsewhere.
        gap_mode = 1'b1;
        for (int w = 0; w < 3; w++) begin
            clear_stim();
            dv[1] = 1'b1;
            de[1] = (w == 2);
            dd[1] = (w == 0) ? 16'hF003 : 16'h5550 + 16'(w);
            step();
            clear_stim();
            repeat (w + 1) step();
        end
        gap_mode = 1'b0;
        repeat (4) step();

        // R1 R3: an unfinished packet is dropped by reset; the next word is a header again.
        clear_stim();
        dv[2] = 1'b1; dd[2] = 16'h1231;
        step();
        do_reset();
        dv[2] = 1'b1; de[2] = 1'b1; dd[2] = 16'hFFFC;
        step();
        clear_stim();
        repeat (2) step();
        step();
        chk(out_valid[0] && out_data[0 +: DW] == 16'h3FFF, "R3 header after mid-packet reset",
            32'(out_data[0 +: DW]), 32'h3FFF);
        chk(out_valid[1] == 1'b0, "R1 stale route cleared by reset", 32'(out_valid), 32'h1);
        repeat (4) step();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule